// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Refresh Engine

This block turns the stored contents of an eight-digit, 5x7 dot-matrix display into row and column drive. The digits form two banks of four. A scan walks through fourteen row slots: the seven rows of bank 0, then the seven rows of bank 1. In each slot one row enable is active and twenty column lines carry that row of the four digits in the active bank. One slot ahead of its display, the block fetches each digit's character code through a read port. Codes with bit 7 clear index a built-in font, which here is a small placeholder. Codes with bit 7 set select one of sixteen user-defined glyphs, and the block reads their rows through a second read port.

Three attributes act on the column lines. A 3-bit brightness code sets how many clocks of each row slot the columns are driven, which lowers average current while the peak drive stays the same. A per-digit flash mask and a whole-display blink each gate columns with a slow phase signal. That signal comes from a counter running at the display clock divided by a configurable ratio. The scan and the phase counter run on either the internal oscillator or an external clock. The oscillator is always passed out so several units can share it. A common reset restarts every counter, which keeps the blink phase of cascaded units aligned.

Top module: `dotmatrix_refresh`

## Requirements
- R1: While `rst_n` is low, `row_en`, `bank_sel` and `col_drive` are all zero.
- R2: After reset the scan repeats fourteen slots of SLOT_CLKS clocks. Slot s (s = 0..13, starting with slot 0) drives `bank_sel` = s/7 and sets only bit s%7 of `row_en`. Exactly one row enable is active at any time after the first slot begins.
- R3: Bits 5k+4 down to 5k of `col_drive` carry digit 4*`bank_sel`+k, with bit 5k+4 as the leftmost column. A lit column is driven high.
- R4: A code with bit 7 clear uses the placeholder font. Code 0x20 gives an all-dark row. Any other code c on row r gives pattern c[4:0] XOR {2'b00, r}, with pattern bit 4 as the leftmost column.
- R5: A code with bit 7 set puts c[3:0] on `udc_sel` and the row number on `udc_row`, and the 5-bit value returned on `udc_pattern` is the row pattern (bit 4 leftmost, 1 lights).
- R6: For `ctrl_bright` codes 0 to 7, the columns of a slot are driven on output clocks 1..n of the slot, with n = 15, 13, 8, 6, 4, 3, 2, 0. Code 7 blanks the display. Driven columns show the full row pattern.
- R7: The first output clock of every row slot has all columns low.
- R8: The phase signal starts in its lit half at reset and toggles every BLINK_DIV/2 scan clocks, so it is aligned with the scan counters. With `ctrl_flash_en` high, a digit whose `flash_mask` bit is set goes dark during the dark half. With `ctrl_flash_en` low, `flash_mask` has no effect.
- R9: With `ctrl_blink_en` high, all columns are dark during the dark half whatever the flash settings are.
- R10: `clk_sel` high runs the block from `osc_clk`, and `clk_sel` low runs it from `ext_clk`. `clk_out` always follows `osc_clk`. While the selected clock is stopped, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External clock from another unit |
| clk_sel | input | 1 | 1 = run from osc_clk, 0 = run from ext_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Oscillator clock passed out for cascading |
| ctrl_bright | input | 3 | Brightness code (0 full, 7 blank) |
| ctrl_flash_en | input | 1 | Enables per-digit flash |
| ctrl_blink_en | input | 1 | Enables whole-display blink |
| flash_mask | input | 8 | One flash bit per digit |
| char_addr | output | 3 | Digit index being fetched |
| char_code | input | 8 | Character code of the fetched digit |
| udc_sel | output | 4 | User glyph index being read |
| udc_row | output | 3 | Row of the user glyph being read |
| udc_pattern | input | 5 | Row pattern of the user glyph |
| row_en | output | 7 | One-hot row enable |
| bank_sel | output | 1 | Active digit bank |
| col_drive | output | 20 | Column drive for the four digits of the bank |

## Verification
The bench keeps SLOT_CLKS at 16 and sets BLINK_DIV to 896. With that value the phase changes every 448 clocks, which is exactly two scan frames and falls on a slot boundary. Every held stimulus setting therefore covers both the lit half and the dark half of flash and blink within a few frames. The 16-clock slot length is kept so that all eight duty lengths can be checked clock by clock.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  localparam int GLYPH_W = 5;
  localparam int CODE_W  = 8;
  localparam int UDC_W   = 4;

  // Driven clocks per sixteen for each brightness code.
  function automatic logic [4:0] duty_sixteenths(input logic [2:0] code);
    logic [4:0] len;
    case (code)
      3'd0:    len = 5'd16;
      3'd1:    len = 5'd13;
      3'd2:    len = 5'd8;
      3'd3:    len = 5'd6;
      3'd4:    len = 5'd4;
      3'd5:    len = 5'd3;
      3'd6:    len = 5'd2;
      default: len = 5'd0;
    endcase
    return len;
  endfunction

  // Placeholder font: blank space, otherwise a code/row dependent pattern.
  function automatic logic [GLYPH_W-1:0] font_row(input logic [6:0] code,
                                                  input logic [2:0] row);
    logic [GLYPH_W-1:0] pat;
    if (code == 7'h20) pat = '0;
    else               pat = code[4:0] ^ {2'b00, row};
    return pat;
  endfunction

endpackage

// File: rtl/dmr_clkrst.sv
module dmr_clkrst (
  input  logic osc_clk,
  input  logic ext_clk,
  input  logic clk_sel,
  input  logic rst_n,
  output logic scan_clk,
  output logic clk_out,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign scan_clk = clk_sel ? osc_clk : ext_clk;
  assign clk_out  = osc_clk;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge scan_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dmr_scan_timer.sv
module dmr_scan_timer #(
  parameter  int SLOT_CLKS   = 16,
  parameter  int SLOTS       = 14,
  parameter  int HALF_PERIOD = 14336,
  localparam int TICK_W      = $clog2(SLOT_CLKS),
  localparam int SLOT_W      = $clog2(SLOTS),
  localparam int PH_W        = $clog2(HALF_PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_end,
  output logic              phase
);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PH_W-1:0]   ph_cnt_q, ph_cnt_d;
  logic              phase_q, phase_d;
  logic              ph_wrap;

  assign slot_end = (tick_q == TICK_W'(SLOT_CLKS - 1));
  assign ph_wrap  = (ph_cnt_q == PH_W'(HALF_PERIOD - 1));

  always_comb begin
    tick_d   = slot_end ? '0 : tick_q + 1'b1;
    slot_d   = slot_q;
    if (slot_end) begin
      if (slot_q == SLOT_W'(SLOTS - 1)) slot_d = '0;
      else                              slot_d = slot_q + 1'b1;
    end
    ph_cnt_d = ph_wrap ? '0 : ph_cnt_q + 1'b1;
    phase_d  = ph_wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      slot_q   <= '0;
      ph_cnt_q <= '0;
      phase_q  <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      slot_q   <= slot_d;
      ph_cnt_q <= ph_cnt_d;
      phase_q  <= phase_d;
    end
  end

  assign tick  = tick_q;
  assign slot  = slot_q;
  assign phase = phase_q;

endmodule

// File: rtl/dmr_glyph_fetch.sv
module dmr_glyph_fetch
  import dmr_pkg::*;
#(
  parameter  int ROWS      = 7,
  parameter  int BANKS     = 2,
  parameter  int DPB       = 4,
  parameter  int SLOT_CLKS = 16,
  localparam int SLOTS     = ROWS * BANKS,
  localparam int TICK_W    = $clog2(SLOT_CLKS),
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int ROW_W     = $clog2(ROWS),
  localparam int BANK_W    = $clog2(BANKS),
  localparam int CHAR_W    = $clog2(BANKS * DPB),
  localparam int PAT_W     = DPB * GLYPH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TICK_W-1:0]  tick,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               slot_end,
  output logic [CHAR_W-1:0]  char_addr,
  input  logic [CODE_W-1:0]  char_code,
  output logic [UDC_W-1:0]   udc_sel,
  output logic [ROW_W-1:0]   udc_row,
  input  logic [GLYPH_W-1:0] udc_pattern,
  output logic [ROW_W-1:0]   disp_row,
  output logic [BANK_W-1:0]  disp_bank,
  output logic [PAT_W-1:0]   disp_pat
);

  int                 tgt;
  logic [ROW_W-1:0]   tgt_row;
  logic [BANK_W-1:0]  tgt_bank;
  logic [GLYPH_W-1:0] glyph;
  logic [PAT_W-1:0]   pend_q, pend_d;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [BANK_W-1:0]  bank_q, bank_d;
  logic [PAT_W-1:0]   pat_q, pat_d;

  // The slot being prepared is the one after the slot on display.
  always_comb begin
    tgt      = (int'(slot) == SLOTS - 1) ? 0 : int'(slot) + 1;
    tgt_row  = ROW_W'(tgt % ROWS);
    tgt_bank = BANK_W'(tgt / ROWS);
  end

  assign char_addr = CHAR_W'(int'(tgt_bank) * DPB + int'(tick) % DPB);
  assign udc_sel   = char_code[UDC_W-1:0];
  assign udc_row   = tgt_row;

  always_comb begin
    if (char_code[CODE_W-1]) glyph = udc_pattern;
    else                     glyph = font_row(char_code[6:0], 3'(tgt_row));
  end

  always_comb begin
    pend_d = pend_q;
    for (int k = 0; k < DPB; k++) begin
      if (int'(tick) == k) pend_d[k*GLYPH_W +: GLYPH_W] = glyph;
    end
    row_d  = slot_end ? tgt_row  : row_q;
    bank_d = slot_end ? tgt_bank : bank_q;
    pat_d  = slot_end ? pend_q   : pat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      row_q  <= '0;
      bank_q <= '0;
      pat_q  <= '0;
    end else begin
      pend_q <= pend_d;
      row_q  <= row_d;
      bank_q <= bank_d;
      pat_q  <= pat_d;
    end
  end

  assign disp_row  = row_q;
  assign disp_bank = bank_q;
  assign disp_pat  = pat_q;

endmodule

// File: rtl/dmr_col_gate.sv
module dmr_col_gate
  import dmr_pkg::*;
#(
  parameter  int ROWS      = 7,
  parameter  int BANKS     = 2,
  parameter  int DPB       = 4,
  parameter  int SLOT_CLKS = 16,
  localparam int TICK_W    = $clog2(SLOT_CLKS),
  localparam int ROW_W     = $clog2(ROWS),
  localparam int BANK_W    = $clog2(BANKS),
  localparam int DIGITS    = BANKS * DPB,
  localparam int PAT_W     = DPB * GLYPH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick,
  input  logic              phase,
  input  logic [ROW_W-1:0]  disp_row,
  input  logic [BANK_W-1:0] disp_bank,
  input  logic [PAT_W-1:0]  disp_pat,
  input  logic [2:0]        ctrl_bright,
  input  logic              flash_en,
  input  logic              blink_en,
  input  logic [DIGITS-1:0] flash_mask,
  output logic [ROWS-1:0]   row_en,
  output logic [BANK_W-1:0] bank_sel,
  output logic [PAT_W-1:0]  col_drive
);

  int                duty_clks;
  logic              lit;
  logic [DPB-1:0]    grp_dark;
  logic [PAT_W-1:0]  col_d, col_q;
  logic [ROWS-1:0]   row_d, row_q;
  logic [BANK_W-1:0] bank_q;

  // Guard clock at tick 0, then the code-dependent number of driven clocks.
  always_comb begin
    duty_clks = int'(duty_sixteenths(ctrl_bright)) * SLOT_CLKS / 16;
    lit       = (tick != '0) && (int'(tick) <= duty_clks);
    row_d     = ROWS'(1) << disp_row;
  end

  for (genvar k = 0; k < DPB; k++) begin : g_grp
    logic flash_bit;
    assign flash_bit   = flash_mask[int'(disp_bank) * DPB + k];
    assign grp_dark[k] = phase & (blink_en | (flash_en & flash_bit));
    assign col_d[k*GLYPH_W +: GLYPH_W] =
      (lit && !grp_dark[k]) ? disp_pat[k*GLYPH_W +: GLYPH_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      row_q  <= row_d;
      bank_q <= disp_bank;
      col_q  <= col_d;
    end
  end

  assign row_en    = row_q;
  assign bank_sel  = bank_q;
  assign col_drive = col_q;

endmodule

// File: rtl/dotmatrix_refresh.sv
module dotmatrix_refresh
  import dmr_pkg::*;
#(
  parameter  int ROWS            = 7,
  parameter  int BANKS           = 2,
  parameter  int DIGITS_PER_BANK = 4,
  parameter  int SLOT_CLKS       = 16,
  parameter  int BLINK_DIV       = 28672,
  localparam int DIGITS          = BANKS * DIGITS_PER_BANK,
  localparam int SLOTS           = ROWS * BANKS,
  localparam int HALF_PERIOD     = BLINK_DIV / 2,
  localparam int TICK_W          = $clog2(SLOT_CLKS),
  localparam int SLOT_W          = $clog2(SLOTS),
  localparam int ROW_W           = $clog2(ROWS),
  localparam int BANK_W          = $clog2(BANKS),
  localparam int CHAR_W          = $clog2(DIGITS),
  localparam int COL_W           = DIGITS_PER_BANK * GLYPH_W
) (
  input  logic               osc_clk,
  input  logic               ext_clk,
  input  logic               clk_sel,
  input  logic               rst_n,
  output logic               clk_out,
  input  logic [2:0]         ctrl_bright,
  input  logic               ctrl_flash_en,
  input  logic               ctrl_blink_en,
  input  logic [DIGITS-1:0]  flash_mask,
  output logic [CHAR_W-1:0]  char_addr,
  input  logic [CODE_W-1:0]  char_code,
  output logic [UDC_W-1:0]   udc_sel,
  output logic [ROW_W-1:0]   udc_row,
  input  logic [GLYPH_W-1:0] udc_pattern,
  output logic [ROWS-1:0]    row_en,
  output logic [BANK_W-1:0]  bank_sel,
  output logic [COL_W-1:0]   col_drive
);

  logic              scan_clk;
  logic              rst_sync_n;
  logic [TICK_W-1:0] tick;
  logic [SLOT_W-1:0] slot;
  logic              slot_end;
  logic              blink_phase;
  logic [ROW_W-1:0]  disp_row;
  logic [BANK_W-1:0] disp_bank;
  logic [COL_W-1:0]  disp_pat;

  dmr_clkrst u_clkrst (
    .osc_clk    (osc_clk),
    .ext_clk    (ext_clk),
    .clk_sel    (clk_sel),
    .rst_n      (rst_n),
    .scan_clk   (scan_clk),
    .clk_out    (clk_out),
    .rst_sync_n (rst_sync_n)
  );

  dmr_scan_timer #(
    .SLOT_CLKS   (SLOT_CLKS),
    .SLOTS       (SLOTS),
    .HALF_PERIOD (HALF_PERIOD)
  ) u_timer (
    .clk      (scan_clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .slot     (slot),
    .slot_end (slot_end),
    .phase    (blink_phase)
  );

  dmr_glyph_fetch #(
    .ROWS      (ROWS),
    .BANKS     (BANKS),
    .DPB       (DIGITS_PER_BANK),
    .SLOT_CLKS (SLOT_CLKS)
  ) u_fetch (
    .clk         (scan_clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .slot        (slot),
    .slot_end    (slot_end),
    .char_addr   (char_addr),
    .char_code   (char_code),
    .udc_sel     (udc_sel),
    .udc_row     (udc_row),
    .udc_pattern (udc_pattern),
    .disp_row    (disp_row),
    .disp_bank   (disp_bank),
    .disp_pat    (disp_pat)
  );

  dmr_col_gate #(
    .ROWS      (ROWS),
    .BANKS     (BANKS),
    .DPB       (DIGITS_PER_BANK),
    .SLOT_CLKS (SLOT_CLKS)
  ) u_gate (
    .clk         (scan_clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .phase       (blink_phase),
    .disp_row    (disp_row),
    .disp_bank   (disp_bank),
    .disp_pat    (disp_pat),
    .ctrl_bright (ctrl_bright),
    .flash_en    (ctrl_flash_en),
    .blink_en    (ctrl_blink_en),
    .flash_mask  (flash_mask),
    .row_en      (row_en),
    .bank_sel    (bank_sel),
    .col_drive   (col_drive)
  );

endmodule

// File: rtl/dmr_chk.sv
module dmr_chk #(
  parameter int ROWS  = 7,
  parameter int COL_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROWS-1:0]  row_en,
  input logic [COL_W-1:0] col_drive,
  input logic [2:0]       ctrl_bright,
  input logic             ctrl_blink_en,
  input logic             blink_phase
);

  // R2
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en));

  // R7
  row_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en != $past(row_en)) |-> (col_drive == '0));

  // R6
  blank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_bright) == 3'd7) |-> (col_drive == '0));

  // R9
  blink_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_blink_en && blink_phase) |-> (col_drive == '0));

endmodule

bind dotmatrix_refresh dmr_chk #(.ROWS(ROWS), .COL_W(COL_W)) u_chk (
  .clk           (scan_clk),
  .rst_n         (rst_n),
  .row_en        (row_en),
  .col_drive     (col_drive),
  .ctrl_bright   (ctrl_bright),
  .ctrl_blink_en (ctrl_blink_en),
  .blink_phase   (blink_phase)
);

// File: tb/tb_dotmatrix_refresh.sv
`timescale 1ns/1ps
module tb_dotmatrix_refresh;

  localparam int SLOT       = 16;
  localparam int NSLOTS     = 14;
  localparam int FRAME      = SLOT * NSLOTS;
  localparam int DIV        = 896;
  localparam int HALF_SLOTS = (DIV / 2) / SLOT;

  logic        osc_clk = 1'b0;
  logic        ext_run, ext_en;
  logic        ext_clk;
  logic        clk_sel, rst_n, clk_out;
  logic [2:0]  ctrl_bright;
  logic        ctrl_flash_en, ctrl_blink_en;
  logic [7:0]  flash_mask;
  logic [2:0]  char_addr;
  logic [7:0]  char_code;
  logic [3:0]  udc_sel;
  logic [2:0]  udc_row;
  logic [4:0]  udc_pattern;
  logic [6:0]  row_en;
  logic        bank_sel;
  logic [19:0] col_drive;

  logic [7:0]  char_mem [8];
  logic [4:0]  udc_mem  [16][8];

  int    tests = 0, fails = 0;
  int    stim_epoch = 0;
  string cur_tag = "R1";
  bit    done = 0;

  always #5 osc_clk = ~osc_clk;
  always @(negedge osc_clk) ext_en <= ext_run;
  assign ext_clk = osc_clk & ext_en;

  assign char_code   = char_mem[char_addr];
  assign udc_pattern = udc_mem[udc_sel][udc_row];

  dotmatrix_refresh #(.BLINK_DIV(DIV)) dut (
    .osc_clk(osc_clk), .ext_clk(ext_clk), .clk_sel(clk_sel), .rst_n(rst_n),
    .clk_out(clk_out), .ctrl_bright(ctrl_bright), .ctrl_flash_en(ctrl_flash_en),
    .ctrl_blink_en(ctrl_blink_en), .flash_mask(flash_mask), .char_addr(char_addr),
    .char_code(char_code), .udc_sel(udc_sel), .udc_row(udc_row),
    .udc_pattern(udc_pattern), .row_en(row_en), .bank_sel(bank_sel),
    .col_drive(col_drive)
  );

  // Expected glyph row from the code rules of R4 and R5.
  function automatic logic [4:0] exp_glyph(input logic [7:0] code, input int row);
    if (code[7])            return udc_mem[code[3:0]][row];
    if (code[6:0] == 7'h20) return 5'd0;
    return code[4:0] ^ 5'(row);
  endfunction

  // Driven clocks per slot from R6.
  function automatic int lit_clocks(input logic [2:0] code);
    case (code)
      3'd0: return 15;  3'd1: return 13;  3'd2: return 8;  3'd3: return 6;
      3'd4: return 4;   3'd5: return 3;   3'd6: return 2;  default: return 0;
    endcase
  endfunction

  function automatic logic [19:0] exp_cols(input int g, input int pos);
    logic [19:0] r;
    int s, bank, row, ph, n, d;
    bit dark;
    r    = '0;
    s    = g % NSLOTS;
    bank = s / 7;
    row  = s % 7;
    ph   = (g / HALF_SLOTS) % 2;
    n    = lit_clocks(ctrl_bright);
    for (int k = 0; k < 4; k++) begin
      d    = bank * 4 + k;
      dark = (ph == 1) && (ctrl_blink_en || (ctrl_flash_en && flash_mask[d]));
      if (pos >= 1 && pos <= n && !dark) r[k*5 +: 5] = exp_glyph(char_mem[d], row);
    end
    return r;
  endfunction

  // Slot monitor
  int          g, pos, slot_ep, prev_ep, bad_pos;
  logic [7:0]  prev_obs, obs;
  bit          bad;
  logic [19:0] bad_act, bad_exp, e;
  string       bad_tag;

  always @(negedge osc_clk) begin
    if (!rst_n) begin
      g = -1; pos = 0; prev_obs = '0; prev_ep = -1; slot_ep = -1; bad = 0;
    end else begin
      obs = {bank_sel, row_en};
      if (obs != prev_obs) begin
        if (g >= 0 && pos == SLOT - 1 && prev_ep >= 0 && prev_ep == stim_epoch) begin
          tests++;
          if (bad) begin
            fails++;
            $display("FAIL %s slot %0d pos %0d: col_drive=%05h expected %05h",
                     bad_tag, g, bad_pos, bad_act, bad_exp);
          end
        end
        g++;
        pos = 0; bad = 0;
        prev_ep = slot_ep; slot_ep = stim_epoch;
        // R2: row/bank for slot g
        tests++;
        if (row_en != 7'(1 << ((g % NSLOTS) % 7)) || bank_sel != 1'((g % NSLOTS) / 7)) begin
          fails++;
          $display("FAIL R2 slot %0d: bank/row=%0d/%07b expected %0d/%07b", g,
                   bank_sel, row_en, (g % NSLOTS) / 7, 7'(1 << ((g % NSLOTS) % 7)));
        end
      end else if (g >= 0) begin
        pos++;
      end
      prev_obs = obs;
      if (g >= 0 && pos < SLOT) begin
        e = exp_cols(g, pos);
        if (e !== col_drive && !bad) begin
          bad = 1; bad_pos = pos; bad_act = col_drive; bad_exp = e;
          bad_tag = (pos == 0) ? "R7" : cur_tag;
        end
      end
    end
  end

  task automatic hold_frames(input int n);
    stim_epoch++;
    repeat (n * FRAME) @(posedge osc_clk);
    #1;
  endtask

  task automatic check1(input string tag, input bit ok, input logic [31:0] act,
                        input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    logic [27:0] snap;
    bit          moved;
    int          g0;
    void'($urandom(32'd20240613));
    rst_n = 0; clk_sel = 1; ext_run = 0;
    ctrl_bright = 0; ctrl_flash_en = 0; ctrl_blink_en = 0; flash_mask = 0;
    for (int i = 0; i < 8; i++) char_mem[i] = 8'h20;
    for (int i = 0; i < 16; i++) for (int r = 0; r < 8; r++) udc_mem[i][r] = 5'($urandom);

    // R1: reset state
    repeat (4) @(posedge osc_clk);
    #1;
    check1("R1", row_en == 0 && col_drive == 0 && bank_sel == 0,
           {bank_sel, row_en, col_drive}, 0);
    rst_n = 1;

    // R4: ASCII font
    cur_tag = "R4";
    for (int i = 0; i < 8; i++) char_mem[i] = {1'b0, 7'($urandom)};
    char_mem[3] = 8'h20;
    hold_frames(3);

    // R5: user glyphs
    cur_tag = "R5";
    for (int i = 0; i < 8; i++) char_mem[i] = {1'b1, 7'($urandom)};
    hold_frames(3);

    // R6: every brightness code, including 7 (blank)
    cur_tag = "R6";
    for (int i = 0; i < 8; i++) char_mem[i] = 8'h1F;
    for (int c = 0; c < 8; c++) begin
      ctrl_bright = 3'(c);
      hold_frames(2);
    end
    ctrl_bright = 0;

    // R8: flash enabled, then mask ignored with flash disabled
    cur_tag = "R8";
    for (int i = 0; i < 8; i++) char_mem[i] = 8'(i + 8'h41);
    flash_mask = 8'b1010_0110; ctrl_flash_en = 1;
    hold_frames(5);
    ctrl_flash_en = 0; flash_mask = 8'hFF;
    hold_frames(5);

    // R9: blink overrides flash
    cur_tag = "R9";
    ctrl_blink_en = 1; ctrl_flash_en = 1; flash_mask = 8'h0F;
    hold_frames(5);
    ctrl_blink_en = 0; ctrl_flash_en = 0;

    // R3: random mixes of codes, masks and attributes
    cur_tag = "R3";
    for (int t = 0; t < 18; t++) begin
      for (int i = 0; i < 8; i++) char_mem[i] = 8'($urandom);
      for (int i = 0; i < 16; i++) udc_mem[i][$urandom_range(0, 6)] = 5'($urandom);
      ctrl_bright   = 3'($urandom_range(0, 7));
      ctrl_flash_en = 1'($urandom);
      ctrl_blink_en = ($urandom_range(0, 3) == 0);
      flash_mask    = 8'($urandom);
      hold_frames(4);
    end
    ctrl_bright = 0; ctrl_blink_en = 0; ctrl_flash_en = 1; flash_mask = 8'h81;

    // R10: external clock selection, hold when stopped, clock pass-through
    cur_tag = "R10";
    rst_n = 0;
    #1;
    check1("R1", row_en == 0 && col_drive == 0, {row_en, col_drive}, 0);
    clk_sel = 0; ext_run = 1;
    repeat (4) @(posedge osc_clk);
    #1;
    rst_n = 1;
    hold_frames(3);
    ext_run = 0;
    repeat (3) @(posedge osc_clk);
    #1;
    snap = {bank_sel, row_en, col_drive};
    moved = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge osc_clk);
      if ({bank_sel, row_en, col_drive} != snap) moved = 1;
    end
    check1("R10 hold", !moved, {bank_sel, row_en, col_drive}, snap);
    @(negedge osc_clk);
    #1;
    check1("R10 clk_out low", clk_out == 1'b0, clk_out, 0);
    @(posedge osc_clk);
    #1;
    check1("R10 clk_out high", clk_out == 1'b1, clk_out, 1);
    g0 = g;
    ext_run = 1;
    hold_frames(2);
    check1("R10 resume", g >= g0 + 20, g, g0 + 20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule